// File: doc/BRIEF.md
# Ordered Tone Period Update Sequencer

This block sits between a controller and a tone generator whose 12-bit period is split into two byte-wide registers. The controller hands over a new period with a valid/ready request. The block compares it with a shadow copy of the period it last programmed, then emits the byte writes needed to move the generator to the new value. The writes are ordered so that the period held in the generator's registers never passes through a value below the smaller of the old and the new period. A value that dips below the running phase counter would restart the tone phase and produce an audible click.

Two orderings are offered, chosen per request by a plain mode pin that is sampled when the request is accepted. Direction ordering writes the low byte first when the period shrinks and the high byte first when it grows. Guard ordering first parks the low byte at all ones, then writes the new high byte, then the new low byte. Writes go out on consecutive clocks, so the whole update completes well inside one generator counter tick.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a sequence is in flight. A request held with `req_valid` high during that time waits, and it is taken on the first edge where `req_ready` is high again. The write side has no back-pressure: the generator must take one write per clock.

Top module: `period_update_seq`

## Requirements
- R1: After reset `req_ready` is high, `wr_en` is low, and the shadow period is 0, so a first request for period 0 produces no write.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance through the cycle of the final write, and high again in the cycle after it. A request held while `req_ready` is low is accepted only once `req_ready` returns high.
- R3: The first write appears in the cycle after acceptance, and the writes of one sequence occupy consecutive cycles with no gap.
- R4: Address 0 carries the low byte as `period[7:0]`. Address 1 carries the high byte as `{4'b0000, period[11:8]}`.
- R5: If exactly one byte of the new period differs from the shadow, only that byte is written, in either mode. If neither byte differs, no write is made and `req_ready` stays high.
- R6: In direction mode (`order_mode`=0), when both bytes differ and the new period is smaller, the sequence is the low byte, then the high byte.
- R7: In direction mode, when both bytes differ and the new period is larger, the sequence is the high byte, then the low byte.
- R8: In guard mode (`order_mode`=1), when both bytes differ, the sequence is: low byte 0xFF, then the new high byte, then the new low byte.
- R9: After every write of a sequence except the last, the period formed by the two generator registers is at least the smaller of the old and the new period. After the last write it equals the new period.
- R10: The shadow takes the new period when a sequence completes, so the next request is compared against the last programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_mode | input | 1 | 0 = direction ordering, 1 = guard ordering; sampled at acceptance |
| req_valid | input | 1 | New period offered |
| req_ready | output | 1 | Block can accept a new period |
| req_period | input | 12 | Requested tone period |
| wr_en | output | 1 | Register write strobe, one write per cycle |
| wr_addr | output | 1 | 0 = low byte register, 1 = high byte register |
| wr_data | output | 8 | Byte to write |

## Verification
Write k of a sequence (counting from 1) is due k cycles after the accepting edge. `req_ready` comes back one cycle after the final write. A request that needs no write leaves `req_ready` high in the very next cycle. The bench drives each request half a cycle before the accepting edge and samples at every following falling edge, one per expected write. At each sample it checks the strobe, address, data and `req_ready`, and it updates a model of the two generator registers that it uses to check the intermediate-value bound. One further falling edge confirms that the strobe has dropped and `req_ready` has returned.

// File: rtl/pus_pkg.sv
package pus_pkg;
  typedef enum logic {
    ORDER_DIR   = 1'b0,
    ORDER_GUARD = 1'b1
  } order_mode_e;

  // register selectors seen by the tone generator
  localparam int unsigned SEL_LO = 0;
  localparam int unsigned SEL_HI = 1;

  // the longest sequence (guard ordering) needs three writes
  localparam int unsigned SEQ_MAX = 3;
endpackage

// File: rtl/pus_shadow.sv
module pus_shadow #(
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [PER_W-1:0] capture_val,
  input  logic             commit,
  output logic [PER_W-1:0] cur_period
);
  logic [PER_W-1:0] pending_q;
  logic [PER_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      shadow_q  <= '0;
    end else begin
      if (capture) pending_q <= capture_val;
      if (commit)  shadow_q  <= pending_q;
    end
  end

  assign cur_period = shadow_q;
endmodule

// File: rtl/pus_planner.sv
module pus_planner
  import pus_pkg::*;
#(
  parameter int unsigned PER_W   = 12,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 1,
  parameter int unsigned MAX_OPS = SEQ_MAX,
  parameter int unsigned CNT_W   = $clog2(MAX_OPS + 1)
) (
  input  order_mode_e       mode,
  input  logic [PER_W-1:0]  cur_p,
  input  logic [PER_W-1:0]  new_p,
  output logic [CNT_W-1:0]  n_ops,
  output logic [ADDR_W-1:0] op_addr [MAX_OPS],
  output logic [DATA_W-1:0] op_data [MAX_OPS]
);
  localparam int unsigned HI_W  = PER_W - DATA_W;
  localparam int unsigned PAD_W = DATA_W - HI_W;

  logic [DATA_W-1:0] lo_new, hi_new;
  logic              lo_diff, hi_diff, shrinking;
  logic [ADDR_W-1:0] a_lo, a_hi;

  assign a_lo      = ADDR_W'(SEL_LO);
  assign a_hi      = ADDR_W'(SEL_HI);
  assign lo_new    = new_p[DATA_W-1:0];
  assign hi_new    = {{PAD_W{1'b0}}, new_p[PER_W-1:DATA_W]};
  assign lo_diff   = (new_p[DATA_W-1:0] != cur_p[DATA_W-1:0]);
  assign hi_diff   = (new_p[PER_W-1:DATA_W] != cur_p[PER_W-1:DATA_W]);
  assign shrinking = (new_p < cur_p);

  always_comb begin
    n_ops = '0;
    for (int i = 0; i < MAX_OPS; i++) begin
      op_addr[i] = '0;
      op_data[i] = '0;
    end
    if (lo_diff && hi_diff) begin
      if (mode == ORDER_GUARD) begin
        n_ops      = CNT_W'(3);
        op_addr[0] = a_lo;  op_data[0] = '1;
        op_addr[1] = a_hi;  op_data[1] = hi_new;
        op_addr[2] = a_lo;  op_data[2] = lo_new;
      end else if (shrinking) begin
        n_ops      = CNT_W'(2);
        op_addr[0] = a_lo;  op_data[0] = lo_new;
        op_addr[1] = a_hi;  op_data[1] = hi_new;
      end else begin
        n_ops      = CNT_W'(2);
        op_addr[0] = a_hi;  op_data[0] = hi_new;
        op_addr[1] = a_lo;  op_data[1] = lo_new;
      end
    end else if (lo_diff) begin
      n_ops      = CNT_W'(1);
      op_addr[0] = a_lo;  op_data[0] = lo_new;
    end else if (hi_diff) begin
      n_ops      = CNT_W'(1);
      op_addr[0] = a_hi;  op_data[0] = hi_new;
    end
  end
endmodule

// File: rtl/pus_issuer.sv
module pus_issuer #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 1,
  parameter int unsigned MAX_OPS = 3,
  parameter int unsigned CNT_W   = $clog2(MAX_OPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  plan_cnt,
  input  logic [ADDR_W-1:0] plan_addr [MAX_OPS],
  input  logic [DATA_W-1:0] plan_data [MAX_OPS],
  output logic              busy,
  output logic              last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned IDX_W = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1;

  logic [ADDR_W-1:0] q_addr [MAX_OPS];
  logic [DATA_W-1:0] q_data [MAX_OPS];
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  assign last = busy_q && ((CNT_W'(idx_q) + CNT_W'(1)) == cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < MAX_OPS; i++) begin
        q_addr[i] <= '0;
        q_data[i] <= '0;
      end
    end else if (load && (plan_cnt != '0)) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= plan_cnt;
      for (int i = 0; i < MAX_OPS; i++) begin
        q_addr[i] <= plan_addr[i];
        q_data[i] <= plan_data[i];
      end
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign busy    = busy_q;
  assign wr_en   = busy_q;
  assign wr_addr = q_addr[idx_q];
  assign wr_data = q_data[idx_q];
endmodule

// File: rtl/period_update_seq.sv
module period_update_seq
  import pus_pkg::*;
#(
  parameter int unsigned PER_W  = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PER_W-1:0]  req_period,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned MAX_OPS = SEQ_MAX;
  localparam int unsigned CNT_W   = $clog2(MAX_OPS + 1);

  logic              accept, busy, last;
  logic [PER_W-1:0]  cur_period;
  logic [CNT_W-1:0]  plan_cnt;
  logic [ADDR_W-1:0] plan_addr [MAX_OPS];
  logic [DATA_W-1:0] plan_data [MAX_OPS];
  order_mode_e       mode_sel;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign mode_sel  = order_mode_e'(order_mode);

  pus_shadow #(.PER_W(PER_W)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (accept),
    .capture_val (req_period),
    .commit      (last),
    .cur_period  (cur_period)
  );

  pus_planner #(
    .PER_W(PER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .MAX_OPS(MAX_OPS), .CNT_W(CNT_W)
  ) u_planner (
    .mode    (mode_sel),
    .cur_p   (cur_period),
    .new_p   (req_period),
    .n_ops   (plan_cnt),
    .op_addr (plan_addr),
    .op_data (plan_data)
  );

  pus_issuer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS), .CNT_W(CNT_W)
  ) u_issuer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .plan_cnt  (plan_cnt),
    .plan_addr (plan_addr),
    .plan_data (plan_data),
    .busy      (busy),
    .last      (last),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );
endmodule

// File: rtl/period_update_seq_chk.sv
module period_update_seq_chk #(
  parameter int unsigned PER_W  = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int unsigned HI_W = PER_W - DATA_W;

  // R2
  ready_drop_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  // R2
  ready_back_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(wr_en));

  // R3
  no_gap_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> wr_en);

  // R2
  write_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_ready);

  // R4
  hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(1)) |-> (wr_data[DATA_W-1:HI_W] == '0));
endmodule

bind period_update_seq period_update_seq_chk #(
  .PER_W(PER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/period_update_seq_bench.sv
`timescale 1ns/1ps
module period_update_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        order_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_period = '0;
  logic        wr_en;
  logic [0:0]  wr_addr;
  logic [7:0]  wr_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the generator registers and of the last programmed period
  logic [7:0]  live_lo = 8'h00;
  logic [3:0]  live_hi = 4'h0;
  logic [11:0] ref_cur = 12'h000;

  always #2 clk = ~clk;

  period_update_seq u_period_update_seq (
    .clk(clk), .rst_n(rst_n), .order_mode(order_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_period(req_period),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // apply the write seen at the ports to the register model
  task automatic apply_write();
    if (wr_addr == 1'b0) live_lo = wr_data;
    else                 live_hi = wr_data[3:0];
  endtask

  // one request; expected writes given as {addr, data}; called and returns at a falling edge
  task automatic run_case(string req, logic [11:0] newp, logic mode, int exp_n,
                          logic [8:0] e0, logic [8:0] e1, logic [8:0] e2);
    logic [8:0]  exp_w [3];
    logic [11:0] bound;
    exp_w[0] = e0; exp_w[1] = e1; exp_w[2] = e2;
    bound = (newp < ref_cur) ? newp : ref_cur;
    chk(req_ready == 1'b1, "R2", "ready before request", int'(req_ready), 1);
    req_period = newp;
    order_mode = mode;
    req_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < exp_n; k++) begin
      chk(wr_en == 1'b1, "R3", "write strobe in sequence", int'(wr_en), 1);
      chk(req_ready == 1'b0, "R2", "ready low while writing", int'(req_ready), 0);
      chk({wr_addr, wr_data} == exp_w[k], req, "write addr/data",
          int'({wr_addr, wr_data}), int'(exp_w[k]));
      apply_write();
      if (k < exp_n - 1)
        chk({live_hi, live_lo} >= bound, "R9", "intermediate period",
            int'({live_hi, live_lo}), int'(bound));
      @(negedge clk);
    end
    chk(wr_en == 1'b0, "R3", "no extra write", int'(wr_en), 0);
    chk(req_ready == 1'b1, "R2", "ready after sequence", int'(req_ready), 1);
    chk({live_hi, live_lo} == newp, "R9", "final period", int'({live_hi, live_lo}), int'(newp));
    ref_cur = newp;
  endtask

  task automatic t_reset();
    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(wr_en == 1'b0, "R1", "no write after reset", int'(wr_en), 0);
    // R1 / R5: shadow is 0, so requesting 0 needs no write
    run_case("R1", 12'h000, 1'b0, 0, '0, '0, '0);
  endtask

  task automatic t_direction();
    // R7: growth 0x000 -> 0x1FE, high byte first
    run_case("R7", 12'h1FE, 1'b0, 2, {1'b1, 8'h01}, {1'b0, 8'hFE}, '0);
    // R6: shrink 0x1FE -> 0x0FF, low byte first
    run_case("R6", 12'h0FF, 1'b0, 2, {1'b0, 8'hFF}, {1'b1, 8'h00}, '0);
  endtask

  task automatic t_single_byte();
    // R5: only the low byte differs (R10: compared against 0x0FF just programmed)
    run_case("R5", 12'h0A0, 1'b0, 1, {1'b0, 8'hA0}, '0, '0);
    // R5: only the high byte differs, R4 padding of the high byte
    run_case("R4", 12'h3A0, 1'b0, 1, {1'b1, 8'h03}, '0, '0);
  endtask

  task automatic t_guard();
    // R8: shrink in guard mode, three writes
    run_case("R8", 12'h2FE, 1'b1, 3, {1'b0, 8'hFF}, {1'b1, 8'h02}, {1'b0, 8'hFE});
    // R8: growth in guard mode
    run_case("R8", 12'hABC, 1'b1, 3, {1'b0, 8'hFF}, {1'b1, 8'h0A}, {1'b0, 8'hBC});
    // R5: one byte differs in guard mode, a single write
    run_case("R5", 12'hA00, 1'b1, 1, {1'b0, 8'h00}, '0, '0);
    // R5 / R10: equal to the programmed value, nothing written
    run_case("R10", 12'hA00, 1'b1, 0, '0, '0, '0);
  endtask

  task automatic t_backpressure();
    // R2: a second request held valid during a sequence waits for ready
    req_period = 12'h5FF; order_mode = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_period = 12'h600;         // next request kept valid while busy
    chk({wr_en, wr_addr, wr_data} == {1'b1, 1'b0, 8'hFF}, "R6", "held: first write",
        int'({wr_en, wr_addr, wr_data}), int'({1'b1, 1'b0, 8'hFF}));
    chk(req_ready == 1'b0, "R2", "held: ready low", int'(req_ready), 0);
    apply_write();
    @(negedge clk);
    chk({wr_en, wr_addr, wr_data} == {1'b1, 1'b1, 8'h05}, "R6", "held: second write",
        int'({wr_en, wr_addr, wr_data}), int'({1'b1, 1'b1, 8'h05}));
    apply_write();
    @(negedge clk);
    chk(wr_en == 1'b0, "R2", "held: gap before next", int'(wr_en), 0);
    chk(req_ready == 1'b1, "R2", "held: ready back", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    // R7: the waiting request grows 0x5FF -> 0x600
    chk({wr_en, wr_addr, wr_data} == {1'b1, 1'b1, 8'h06}, "R7", "held: third write",
        int'({wr_en, wr_addr, wr_data}), int'({1'b1, 1'b1, 8'h06}));
    apply_write();
    @(negedge clk);
    chk({wr_en, wr_addr, wr_data} == {1'b1, 1'b0, 8'h00}, "R7", "held: fourth write",
        int'({wr_en, wr_addr, wr_data}), int'({1'b1, 1'b0, 8'h00}));
    apply_write();
    @(negedge clk);
    chk(wr_en == 1'b0, "R2", "held: done", int'(wr_en), 0);
    chk({live_hi, live_lo} == 12'h600, "R9", "held: final period", int'({live_hi, live_lo}), 'h600);
    ref_cur = 12'h600;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_single_byte();
    t_guard();
    t_backpressure();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule